// File: doc/BRIEF.md
# Fractional Audio Bit-Clock Divider

This block derives a serial audio bit clock from the system clock using a programmable rational ratio. The ratio is held as a 15-bit numerator over a 9-bit denominator. A phase accumulator adds the denominator on every system clock. Each time the running sum reaches the numerator, the accumulator drops back by the numerator and the bit clock flips.

The output therefore runs at Fclk·DEN/(2·NUM). When the quotient is not a whole number, the bit-clock period alternates between neighbouring cycle counts. The average rate is still exact, even though the edges are not evenly spaced. To choose a ratio for sample rate Fs and word size W, set NUM/DEN to Fclk/(4·W·Fs). For example, at 24 MHz a setting of 375/8 gives 8 kHz at 16-bit words.

Software loads the ratio one 8-bit slice at a time. The block checks that the ratio is at least 3.35. An illegal ratio holds the clock low and raises an error flag. Alongside the clock level, the block emits one-cycle rise and fall strobes, so a serializer in the system clock domain can act on the clock edges without sampling the clock itself.

Top module: `frac_bclk_div`

## Requirements
- R1: After reset the stored numerator and denominator are zero, sck, sck_rise and sck_fall are low, and cfg_err is high.
- R2: A write with cfg_sel=0 loads DEN[7:0] from cfg_data. A write with cfg_sel=1 loads NUM[7:0]. A write with cfg_sel=2 loads NUM[14:8] from cfg_data[6:0] and DEN[8] from cfg_data[7].
- R3: A write with cfg_sel=3 leaves the numerator and the denominator unchanged.
- R4: Count the clock edges where en=1, cfg_wr=0 and cfg_err=0 since the last restart. After n such edges, sck equals the parity of floor(n·DEN/NUM).
- R5: sck_rise is high for exactly the one cycle in which sck has just gone from 0 to 1 through a toggle. sck_fall is high for exactly the one cycle in which sck has just gone from 1 to 0 through a toggle. The two are never high together.
- R6: cfg_err is high exactly when NUM=0, DEN=0, or 100·NUM < 335·DEN. cfg_err follows the stored values from the cycle after the write edge.
- R7: While cfg_err is high, sck stays low and neither strobe fires.
- R8: On an edge with en=0 the accumulator clears and sck goes low. Counting for R4 restarts from zero.
- R9: Any edge with cfg_wr=1 clears the accumulator and drives sck low, whatever the value of cfg_sel. Counting for R4 restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Divider run enable |
| cfg_wr | input | 1 | Slice write strobe |
| cfg_sel | input | 2 | Slice select: 0 low, 1 middle, 2 upper, 3 none |
| cfg_data | input | 8 | Slice write data |
| sck | output | 1 | Bit clock level |
| sck_rise | output | 1 | One-cycle strobe: sck has just risen |
| sck_fall | output | 1 | One-cycle strobe: sck has just fallen |
| cfg_err | output | 1 | Stored ratio is illegal |

## Verification
sck and both strobes come from one register stage, so each toggle decision is visible at the falling edge right after the clock edge that made it. cfg_err is decoded from the stored ratio, so it is valid half a cycle after the write edge. The bench drives every input at falling edges and samples at the next falling edge. For each counted edge n it compares sck against the parity of floor(n·DEN/NUM) and checks that the strobes match the change in that count. After every disable or write, n restarts from zero.

// File: rtl/frac_bclk_pkg.sv
package frac_bclk_pkg;
    localparam int NUM_W    = 15;
    localparam int DEN_W    = 9;
    localparam int SLICE_W  = 8;
    localparam int ACC_W    = 16;
    localparam int NUM_HI_W = NUM_W - SLICE_W;
    localparam int DEN_HI_W = DEN_W - SLICE_W;
    localparam int LIM_NUM  = 335;
    localparam int LIM_DEN  = 100;

    typedef struct packed {
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] den;
    } ratio_t;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_MID  = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } slice_sel_e;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             sck;
        logic             rise;
        logic             fall;
    } phase_t;
endpackage

// File: rtl/frac_bclk_cfg.sv
module frac_bclk_cfg
    import frac_bclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [1:0]         sel,
    input  logic [SLICE_W-1:0] data,
    output ratio_t             ratio
);
    ratio_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (slice_sel_e'(sel))
                SEL_LO:  cfg_d.den[SLICE_W-1:0] = data;
                SEL_MID: cfg_d.num[SLICE_W-1:0] = data;
                SEL_HI: begin
                    cfg_d.num[NUM_W-1:SLICE_W] = data[NUM_HI_W-1:0];
                    cfg_d.den[DEN_W-1:SLICE_W] = data[SLICE_W-1 -: DEN_HI_W];
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ratio = cfg_q;
endmodule

// File: rtl/frac_bclk_legal.sv
module frac_bclk_legal
    import frac_bclk_pkg::*;
(
    input  ratio_t ratio,
    output logic   legal
);
    localparam int PW = NUM_W + 9;
    logic [PW-1:0] lhs, rhs;

    always_comb begin
        lhs   = PW'(ratio.num) * PW'(LIM_DEN);
        rhs   = PW'(ratio.den) * PW'(LIM_NUM);
        legal = (ratio.num != '0) && (ratio.den != '0) && (lhs >= rhs);
    end
endmodule

// File: rtl/frac_bclk_phase.sv
module frac_bclk_phase
    import frac_bclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  ratio_t           ratio,
    output logic [ACC_W-1:0] acc,
    output logic             sck,
    output logic             rise,
    output logic             fall
);
    localparam int SW = ACC_W + 1;
    phase_t ph_d, ph_q;
    logic [SW-1:0] sum, num_x, den_x, rem;

    always_comb begin
        num_x = SW'(ratio.num);
        den_x = SW'(ratio.den);
        sum   = SW'(ph_q.acc) + den_x;
        rem   = sum - num_x;
        ph_d      = ph_q;
        ph_d.rise = 1'b0;
        ph_d.fall = 1'b0;
        if (clr) begin
            ph_d.acc = '0;
            ph_d.sck = 1'b0;
        end else if (run) begin
            if (sum >= num_x) begin
                ph_d.acc  = rem[ACC_W-1:0];
                ph_d.sck  = ~ph_q.sck;
                ph_d.rise = ~ph_q.sck;
                ph_d.fall = ph_q.sck;
            end else begin
                ph_d.acc = sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign acc  = ph_q.acc;
    assign sck  = ph_q.sck;
    assign rise = ph_q.rise;
    assign fall = ph_q.fall;
endmodule

// File: rtl/frac_bclk_div.sv
module frac_bclk_div
    import frac_bclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_sel,
    input  logic [SLICE_W-1:0] cfg_data,
    output logic               sck,
    output logic               sck_rise,
    output logic               sck_fall,
    output logic               cfg_err
);
    ratio_t           ratio_w;
    logic             legal_w;
    logic             run_w, clr_w;
    logic [ACC_W-1:0] acc_w;

    frac_bclk_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
        .data(cfg_data), .ratio(ratio_w)
    );

    frac_bclk_legal u_legal (.ratio(ratio_w), .legal(legal_w));

    always_comb begin
        run_w = en && legal_w && !cfg_wr;
        clr_w = cfg_wr || !en || !legal_w;
    end

    frac_bclk_phase u_phase (
        .clk(clk), .rst_n(rst_n), .run(run_w), .clr(clr_w), .ratio(ratio_w),
        .acc(acc_w), .sck(sck), .rise(sck_rise), .fall(sck_fall)
    );

    assign cfg_err = !legal_w;
endmodule

// File: rtl/frac_bclk_div_chk.sv
module frac_bclk_div_chk
    import frac_bclk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             cfg_wr,
    input logic             sck,
    input logic             sck_rise,
    input logic             sck_fall,
    input logic             cfg_err,
    input logic [ACC_W-1:0] acc,
    input ratio_t           ratio
);
    p_rise_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |-> (sck && !$past(sck)));
    p_fall_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sck_fall |-> (!sck && $past(sck)));
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sck_rise && sck_fall));
    p_rose_has_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> sck_rise);
    p_err_holds_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!sck && !sck_rise && !sck_fall));
    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sck && acc == '0));
    p_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (!sck && acc == '0));
    p_acc_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_err && en) |-> (ACC_W'(ratio.num) > acc || acc == '0));
endmodule

bind frac_bclk_div frac_bclk_div_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .sck(sck),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cfg_err(cfg_err),
    .acc(acc_w), .ratio(ratio_w)
);

// File: tb/sim_frac_bclk_div.sv
module sim_frac_bclk_div;
    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_data = 8'd0;
    logic       sck, sck_rise, sck_fall, cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    frac_bclk_div u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .sck(sck), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cfg_err(cfg_err)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic longint toggles(longint n, longint d, longint nm);
        return (n * d) / nm;
    endfunction

    function automatic bit illegal(int nm, int d);
        return (nm == 0) || (d == 0) || (nm * 100 < d * 335);
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic write_slice(int sel, int data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_data = 8'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic configure(int nm, int d);
        write_slice(0, d & 8'hff);
        write_slice(1, nm & 8'hff);
        write_slice(2, ((d >> 8) & 1) << 7 | ((nm >> 8) & 7'h7f));
        check("R6 cfg_err", cfg_err, illegal(nm, d));
    endtask

    // en must already be 1 at the current falling edge; count restarts at zero
    task automatic run_phase(string tag, int nm, int d, int cycles);
        for (int k = 1; k <= cycles; k++) begin
            longint t1, t0;
            @(negedge clk);
            t1 = toggles(k, d, nm);
            t0 = toggles(k - 1, d, nm);
            check({tag, " sck"}, sck, t1 % 2);
            check({tag, " rise R5"}, sck_rise, (t1 != t0) && (t1 % 2 == 1));
            check({tag, " fall R5"}, sck_fall, (t1 != t0) && (t1 % 2 == 0));
        end
    endtask

    task automatic start_run(string tag, int nm, int d, int cycles);
        en = 1'b1;
        run_phase(tag, nm, d, cycles);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        #(PERIOD * 3);
        @(negedge clk);
        check("R1 sck", sck, 0);
        check("R1 rise", sck_rise, 0);
        check("R1 fall", sck_fall, 0);
        check("R1 cfg_err", cfg_err, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cfg_err after release", cfg_err, 1);

        // directed: 375/8 and 375/4
        configure(375, 8);
        start_run("R4 375/8", 375, 8, 800);
        en = 1'b0;
        @(negedge clk);
        check("R8 sck low on disable", sck, 0);
        configure(375, 4);
        start_run("R4 375/4", 375, 4, 400);

        // R8: disable mid-run, then restart from zero
        en = 1'b0;
        @(negedge clk);
        check("R8 sck", sck, 0);
        check("R8 rise", sck_rise, 0);
        start_run("R8 restart", 375, 4, 300);

        // R9 and R3: a write to sel 3 restarts phase but keeps the ratio
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_data = 8'hff;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R9 sck after write", sck, 0);
        check("R3 cfg_err unchanged", cfg_err, 0);
        run_phase("R3 ratio kept", 375, 4, 300);

        // R2: upper slice with DEN bit 8 set
        en = 1'b0;
        configure(16'h1234, 300);
        start_run("R2 packing", 16'h1234, 300, 400);
        en = 1'b0;
        configure(7'h55 << 8 | 8'h0f, 511);
        start_run("R2 packing hi", 7'h55 << 8 | 8'h0f, 511, 300);

        // R6 boundary: 67/20 is exactly 3.35, 66/20 is below
        en = 1'b0;
        configure(67, 20);
        start_run("R6 boundary legal", 67, 20, 200);
        en = 1'b0;
        configure(66, 20);
        en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            check("R7 sck held low", sck, 0);
            check("R7 rise", sck_rise, 0);
            check("R7 fall", sck_fall, 0);
        end
        en = 1'b0;
        configure(500, 0);
        check("R6 den zero", cfg_err, 1);
        configure(0, 8);
        check("R6 num zero", cfg_err, 1);
        en = 1'b1;
        repeat (20) begin
            @(negedge clk);
            check("R7 num zero low", sck, 0);
        end

        // random legal ratios
        for (int t = 0; t < 10; t++) begin
            int d, mn, nm;
            d  = 1 + int'($urandom % 511);
            mn = (d * 335 + 99) / 100;
            nm = mn + int'($urandom % (mn * 3 + 1));
            if (nm > 32767) nm = 32767;
            en = 1'b0;
            configure(nm, d);
            start_run("R4 random", nm, d, 500);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule